// File: doc/BRIEF.md
# Processor Exception Cause and Vector Unit

This unit sits beside an in-order pipeline and decides, every cycle, whether control must move to an exception handler. The instruction that completes in a cycle is described by class flags, the low two bits of its effective address and the page and cache attributes. The unit also receives the machine-state control bits (user mode, FP available, single-step, branch-trace, FP-enable modes, external-enable), the FP status and enable vectors, the external interrupt level and the decrementer's most significant bit.

From these inputs the unit picks one cause under a fixed priority. One cycle later it drives a single-cycle take strobe together with the cause code, the program sub-cause bits and the handler address. The handler address is a runtime base plus the cause's offset. A decrementer request is recorded on the rising edge of the MSB and kept until it is taken or cleared. An external interrupt first holds off dispatch, and it is only taken once the pipeline has drained.

Top module: `exc_unit`

## Requirements
- R1: A cause chosen from the inputs of cycle t shows after the following clock edge as take_o=1 for one cycle. In that cycle vector_o = vec_base_i (of cycle t) + cause_o·0x100. cause_o is 4'h5 external, 4'h6 alignment, 4'h7 program, 4'h8 FP unavailable, 4'h9 decrementer, 4'hC system call, 4'hD trace. The codes 4'hA, 4'hB and 4'hE are never produced. When take_o=0, cause_o and prog_bits_o are 0.
- R2: Alignment (4'h6) is raised when a completing FP load/store, load/store-multiple, reserved load/conditional store or external-control word access has ea_lo_i≠0. It is also raised when a zero-cache-block operation sees a caching-inhibited page, a write-through page, a locked data cache or a disabled data cache. Word alignment does not matter for a zero-cache-block operation.
- R3: Program (4'h7) carries prog_bits_o with bit1 for an illegal or unimplemented opcode, bit2 for a privileged instruction in user mode or for an SPR move with an invalid field and SPR MSB 1 in user mode, and bit3 for a trap hit. All bits that apply are set together.
- R4: The FP-enabled program cause (prog_bits_o bit0) needs an FP operation with FP available, at least one status bit whose enable bit is also set, and at least one of the two FP-enable mode bits set.
- R5: An FP operation or FP load/store while FP is not available raises 4'h8.
- R6: With the external interrupt enabled, dispatch_stop_o rises after one edge and stays high. Exceptions of completing instructions are taken meanwhile. 4'h5 is taken only in a cycle with pipe_empty_i=1 and no completing instruction, after which dispatch_stop_o falls.
- R7: A 0→1 change of the decrementer MSB latches a request, and a held 1 does not latch another. The request stays until it is taken or dec_clr_i clears it.
- R8: Trace (4'hD) follows a completing instruction without its own exception when single-step is set and it is not a return-from-interrupt, or when branch-trace is set and it is a branch.
- R9: A completing system call raises 4'hC.
- R10: The priority order is program, FP unavailable, alignment, system call, trace, decrementer, external.
- R11: Decrementer and external requests are taken only while the external-enable bit is set. With that bit clear, an external interrupt neither stops dispatch nor is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_base_i | input | VA_W | Handler table base |
| instr_valid_i | input | 1 | An instruction completes this cycle |
| ea_lo_i | input | 2 | Low address bits of its access |
| fp_mem_i | input | 1 | FP load or store |
| lsm_i | input | 1 | Load/store multiple word |
| resv_i | input | 1 | Reserved load or conditional store |
| ext_ctl_i | input | 1 | External-control word access |
| dcbz_i | input | 1 | Zero-cache-block operation |
| page_ci_i | input | 1 | Page caching-inhibited |
| page_wt_i | input | 1 | Page write-through |
| dc_lock_i | input | 1 | Data cache locked |
| dc_off_i | input | 1 | Data cache disabled |
| illegal_i | input | 1 | Illegal opcode combination |
| unimpl_i | input | 1 | Unimplemented optional instruction |
| priv_i | input | 1 | Privileged instruction |
| spr_move_i | input | 1 | Move to/from SPR |
| spr_bad_i | input | 1 | SPR field invalid |
| spr_msb_i | input | 1 | Top bit of SPR field |
| trap_hit_i | input | 1 | Trap condition met |
| fp_op_i | input | 1 | FP arithmetic or move |
| sc_i | input | 1 | System call |
| rfi_i | input | 1 | Return from interrupt |
| branch_i | input | 1 | Branch |
| msr_pr_i | input | 1 | User mode |
| msr_fp_i | input | 1 | FP available |
| msr_se_i | input | 1 | Single-step trace enable |
| msr_be_i | input | 1 | Branch trace enable |
| msr_ee_i | input | 1 | External-enable |
| msr_fe0_i | input | 1 | FP-enable mode bit 0 |
| msr_fe1_i | input | 1 | FP-enable mode bit 1 |
| fpx_stat_i | input | FPX_W | FP exception status bits |
| fpx_en_i | input | FPX_W | FP exception enable bits |
| ext_int_i | input | 1 | External interrupt level |
| dec_msb_i | input | 1 | Decrementer MSB |
| dec_clr_i | input | 1 | Clear pending decrementer request |
| pipe_empty_i | input | 1 | No dispatched instruction outstanding |
| take_o | output | 1 | Exception entry strobe |
| vector_o | output | VA_W | Handler address |
| cause_o | output | 4 | Cause code |
| prog_bits_o | output | 4 | Program sub-cause bits |
| dispatch_stop_o | output | 1 | Hold dispatch while draining |

## Verification
Three pairs of functions can meet in one cycle. The first is a decrementer request and an external interrupt: both are raised on the same edge with an empty pipeline, and the bench expects the decrementer entry one cycle before the external entry while dispatch stays held. The second is a pending decrementer request and a completing system call: the system call has to win, and the decrementer follows in the next cycle. The third is a completing instruction's exception and an external interrupt that is still draining: the instruction's exception has to be taken while dispatch_stop_o stays high, and the external entry waits for the empty pipeline. The synchronous causes are swept exhaustively over their flags, with the expected winner computed from the priority order.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    CAUSE_NONE  = 4'h0,
    CAUSE_EXT   = 4'h5,
    CAUSE_ALIGN = 4'h6,
    CAUSE_PROG  = 4'h7,
    CAUSE_FPU   = 4'h8,
    CAUSE_DEC   = 4'h9,
    CAUSE_SC    = 4'hC,
    CAUSE_TRACE = 4'hD
  } cause_e;

  localparam int PROG_W  = 4;
  localparam int PB_FPE  = 0;
  localparam int PB_ILL  = 1;
  localparam int PB_PRIV = 2;
  localparam int PB_TRAP = 3;
  localparam int OFS_SH  = 8;

  typedef enum logic {ST_RUN = 1'b0, ST_DRAIN = 1'b1} drain_e;
endpackage

// File: rtl/exc_sync_detect.sv
module exc_sync_detect
  import exc_pkg::*;
#(
  parameter int FPX_W = 5
) (
  input  logic              valid_i,
  input  logic [1:0]        ea_lo_i,
  input  logic              fp_mem_i,
  input  logic              lsm_i,
  input  logic              resv_i,
  input  logic              ext_ctl_i,
  input  logic              dcbz_i,
  input  logic              page_ci_i,
  input  logic              page_wt_i,
  input  logic              dc_lock_i,
  input  logic              dc_off_i,
  input  logic              illegal_i,
  input  logic              unimpl_i,
  input  logic              priv_i,
  input  logic              spr_move_i,
  input  logic              spr_bad_i,
  input  logic              spr_msb_i,
  input  logic              trap_hit_i,
  input  logic              fp_op_i,
  input  logic              sc_i,
  input  logic              rfi_i,
  input  logic              branch_i,
  input  logic              msr_pr_i,
  input  logic              msr_fp_i,
  input  logic              msr_se_i,
  input  logic              msr_be_i,
  input  logic              msr_fe0_i,
  input  logic              msr_fe1_i,
  input  logic [FPX_W-1:0]  fpx_stat_i,
  input  logic [FPX_W-1:0]  fpx_en_i,
  output logic              align_o,
  output logic              prog_o,
  output logic              fpu_o,
  output logic              sc_o,
  output logic              trace_o,
  output logic [PROG_W-1:0] prog_bits_o
);
  logic fex, misal, word_cls, dcbz_bad, fp_any, own_exc;

  always_comb begin
    fex      = |(fpx_stat_i & fpx_en_i);
    misal    = (ea_lo_i != 2'b00);
    word_cls = fp_mem_i | lsm_i | resv_i | ext_ctl_i;
    dcbz_bad = dcbz_i & (page_ci_i | page_wt_i | dc_lock_i | dc_off_i);
    fp_any   = fp_op_i | fp_mem_i;

    prog_bits_o          = '0;
    prog_bits_o[PB_FPE]  = valid_i & fp_op_i & msr_fp_i & fex & (msr_fe0_i | msr_fe1_i);
    prog_bits_o[PB_ILL]  = valid_i & (illegal_i | unimpl_i);
    prog_bits_o[PB_PRIV] = valid_i & msr_pr_i & (priv_i | (spr_move_i & spr_bad_i & spr_msb_i));
    prog_bits_o[PB_TRAP] = valid_i & trap_hit_i;

    prog_o  = |prog_bits_o;
    fpu_o   = valid_i & fp_any & ~msr_fp_i;
    align_o = valid_i & ((word_cls & misal) | dcbz_bad);
    sc_o    = valid_i & sc_i;
    own_exc = prog_o | fpu_o | align_o | sc_o;
    trace_o = valid_i & ~own_exc & ((msr_se_i & ~rfi_i) | (msr_be_i & branch_i));
  end
endmodule

// File: rtl/exc_async_ctl.sv
module exc_async_ctl
  import exc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_msb_i,
  input  logic dec_clr_i,
  input  logic dec_take_i,
  input  logic ext_int_i,
  input  logic ee_i,
  input  logic ext_take_i,
  output logic dec_pend_o,
  output logic drain_o
);
  logic   msb_q, dec_edge;
  drain_e st_q, st_d;

  assign dec_edge = dec_msb_i & ~msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q      <= 1'b0;
      dec_pend_o <= 1'b0;
    end else begin
      msb_q      <= dec_msb_i;
      // a new edge beats a clear or a take of the older request
      dec_pend_o <= (dec_pend_o & ~dec_clr_i & ~dec_take_i) | dec_edge;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (ext_int_i && ee_i) st_d = ST_DRAIN;
      ST_DRAIN: if (ext_take_i || !(ext_int_i && ee_i)) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign drain_o = (st_q == ST_DRAIN);

  AST_DEC_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_pend_o) |-> $past(dec_msb_i)) else $error("dec pend without msb"); // R7
  AST_DEC_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_pend_o && !dec_clr_i && !dec_take_i |=> dec_pend_o) else $error("dec pend lost"); // R7
  AST_DRAIN_NEEDS_EE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_o) |-> $past(ext_int_i && ee_i)) else $error("drain without enabled int"); // R11
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int FPX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   vec_base_i,
  input  logic              instr_valid_i,
  input  logic [1:0]        ea_lo_i,
  input  logic              fp_mem_i,
  input  logic              lsm_i,
  input  logic              resv_i,
  input  logic              ext_ctl_i,
  input  logic              dcbz_i,
  input  logic              page_ci_i,
  input  logic              page_wt_i,
  input  logic              dc_lock_i,
  input  logic              dc_off_i,
  input  logic              illegal_i,
  input  logic              unimpl_i,
  input  logic              priv_i,
  input  logic              spr_move_i,
  input  logic              spr_bad_i,
  input  logic              spr_msb_i,
  input  logic              trap_hit_i,
  input  logic              fp_op_i,
  input  logic              sc_i,
  input  logic              rfi_i,
  input  logic              branch_i,
  input  logic              msr_pr_i,
  input  logic              msr_fp_i,
  input  logic              msr_se_i,
  input  logic              msr_be_i,
  input  logic              msr_ee_i,
  input  logic              msr_fe0_i,
  input  logic              msr_fe1_i,
  input  logic [FPX_W-1:0]  fpx_stat_i,
  input  logic [FPX_W-1:0]  fpx_en_i,
  input  logic              ext_int_i,
  input  logic              dec_msb_i,
  input  logic              dec_clr_i,
  input  logic              pipe_empty_i,
  output logic              take_o,
  output logic [VA_W-1:0]   vector_o,
  output logic [3:0]        cause_o,
  output logic [PROG_W-1:0] prog_bits_o,
  output logic              dispatch_stop_o
);
  localparam int PAD_W = VA_W - 4 - OFS_SH;

  logic              s_align, s_prog, s_fpu, s_sc, s_trace;
  logic [PROG_W-1:0] s_pbits;
  logic              dec_pend, drain, dec_go, ext_go;
  cause_e            cause_d;

  exc_sync_detect #(.FPX_W(FPX_W)) u_detect (
    .valid_i(instr_valid_i), .ea_lo_i(ea_lo_i), .fp_mem_i(fp_mem_i), .lsm_i(lsm_i),
    .resv_i(resv_i), .ext_ctl_i(ext_ctl_i), .dcbz_i(dcbz_i), .page_ci_i(page_ci_i),
    .page_wt_i(page_wt_i), .dc_lock_i(dc_lock_i), .dc_off_i(dc_off_i),
    .illegal_i(illegal_i), .unimpl_i(unimpl_i), .priv_i(priv_i), .spr_move_i(spr_move_i),
    .spr_bad_i(spr_bad_i), .spr_msb_i(spr_msb_i), .trap_hit_i(trap_hit_i),
    .fp_op_i(fp_op_i), .sc_i(sc_i), .rfi_i(rfi_i), .branch_i(branch_i),
    .msr_pr_i(msr_pr_i), .msr_fp_i(msr_fp_i), .msr_se_i(msr_se_i), .msr_be_i(msr_be_i),
    .msr_fe0_i(msr_fe0_i), .msr_fe1_i(msr_fe1_i), .fpx_stat_i(fpx_stat_i),
    .fpx_en_i(fpx_en_i), .align_o(s_align), .prog_o(s_prog), .fpu_o(s_fpu),
    .sc_o(s_sc), .trace_o(s_trace), .prog_bits_o(s_pbits)
  );

  exc_async_ctl u_async (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_msb_i(dec_msb_i), .dec_clr_i(dec_clr_i),
    .dec_take_i(cause_d == CAUSE_DEC), .ext_int_i(ext_int_i), .ee_i(msr_ee_i),
    .ext_take_i(cause_d == CAUSE_EXT), .dec_pend_o(dec_pend), .drain_o(drain)
  );

  assign dec_go = dec_pend & msr_ee_i;
  assign ext_go = drain & ext_int_i & msr_ee_i & pipe_empty_i & ~instr_valid_i;

  always_comb begin
    if      (s_prog)  cause_d = CAUSE_PROG;
    else if (s_fpu)   cause_d = CAUSE_FPU;
    else if (s_align) cause_d = CAUSE_ALIGN;
    else if (s_sc)    cause_d = CAUSE_SC;
    else if (s_trace) cause_d = CAUSE_TRACE;
    else if (dec_go)  cause_d = CAUSE_DEC;
    else if (ext_go)  cause_d = CAUSE_EXT;
    else              cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o      <= 1'b0;
      cause_o     <= 4'h0;
      prog_bits_o <= '0;
      vector_o    <= '0;
    end else begin
      take_o      <= (cause_d != CAUSE_NONE);
      cause_o     <= cause_d;
      prog_bits_o <= (cause_d == CAUSE_PROG) ? s_pbits : '0;
      vector_o    <= vec_base_i + {{PAD_W{1'b0}}, cause_d, {OFS_SH{1'b0}}};
    end
  end

  assign dispatch_stop_o = drain;

  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (cause_o inside {4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hC, 4'hD})) else $error("bad cause"); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cause_o == 4'h0 && prog_bits_o == '0)) else $error("stale cause"); // R1
  AST_PROG_HAS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && cause_o == 4'h7 |-> prog_bits_o != '0) else $error("program w/o bits"); // R3
  AST_EXT_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && cause_o == 4'h5 |-> $past(pipe_empty_i && !instr_valid_i && dispatch_stop_o)) else $error("ext not drained"); // R6
  AST_ASYNC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && (cause_o == 4'h5 || cause_o == 4'h9) |-> $past(msr_ee_i)) else $error("async while masked"); // R11
endmodule

// File: tb/exc_unit_bench.sv
module exc_unit_bench;
  localparam int CLK_T = 10;
  localparam int VA_W  = 32;
  localparam int FPX_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [VA_W-1:0] vec_base;
  logic instr_valid, fp_mem, lsm, resv, ext_ctl, dcbz, page_ci, page_wt, dc_lock, dc_off;
  logic [1:0] ea_lo;
  logic illegal, unimpl, priv, spr_move, spr_bad, spr_msb, trap_hit, fp_op, sc, rfi, branch;
  logic msr_pr, msr_fp, msr_se, msr_be, msr_ee, msr_fe0, msr_fe1;
  logic [FPX_W-1:0] fpx_stat, fpx_en;
  logic ext_int, dec_msb, dec_clr, pipe_empty;
  logic take;
  logic [VA_W-1:0] vector;
  logic [3:0] cause, pbits;
  logic stop;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  exc_unit #(.VA_W(VA_W), .FPX_W(FPX_W)) u_exc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .vec_base_i(vec_base), .instr_valid_i(instr_valid),
    .ea_lo_i(ea_lo), .fp_mem_i(fp_mem), .lsm_i(lsm), .resv_i(resv), .ext_ctl_i(ext_ctl),
    .dcbz_i(dcbz), .page_ci_i(page_ci), .page_wt_i(page_wt), .dc_lock_i(dc_lock),
    .dc_off_i(dc_off), .illegal_i(illegal), .unimpl_i(unimpl), .priv_i(priv),
    .spr_move_i(spr_move), .spr_bad_i(spr_bad), .spr_msb_i(spr_msb), .trap_hit_i(trap_hit),
    .fp_op_i(fp_op), .sc_i(sc), .rfi_i(rfi), .branch_i(branch), .msr_pr_i(msr_pr),
    .msr_fp_i(msr_fp), .msr_se_i(msr_se), .msr_be_i(msr_be), .msr_ee_i(msr_ee),
    .msr_fe0_i(msr_fe0), .msr_fe1_i(msr_fe1), .fpx_stat_i(fpx_stat), .fpx_en_i(fpx_en),
    .ext_int_i(ext_int), .dec_msb_i(dec_msb), .dec_clr_i(dec_clr), .pipe_empty_i(pipe_empty),
    .take_o(take), .vector_o(vector), .cause_o(cause), .prog_bits_o(pbits),
    .dispatch_stop_o(stop)
  );

  task automatic clr_instr();
    instr_valid = 0; ea_lo = 0; fp_mem = 0; lsm = 0; resv = 0; ext_ctl = 0; dcbz = 0;
    page_ci = 0; page_wt = 0; dc_lock = 0; dc_off = 0; illegal = 0; unimpl = 0; priv = 0;
    spr_move = 0; spr_bad = 0; spr_msb = 0; trap_hit = 0; fp_op = 0; sc = 0; rfi = 0; branch = 0;
  endtask

  task automatic clr_all();
    clr_instr();
    msr_pr = 0; msr_fp = 1; msr_se = 0; msr_be = 0; msr_ee = 0; msr_fe0 = 0; msr_fe1 = 0;
    fpx_stat = '0; fpx_en = '0; ext_int = 0; dec_msb = 0; dec_clr = 0; pipe_empty = 1;
  endtask

  // compare registered outputs with expectation
  task automatic expect_out(input logic et, input logic [3:0] ec, input logic [3:0] ep, input string tag);
    logic [VA_W-1:0] ev;
    logic bad;
    ev = vec_base + (VA_W'(ec) << 8);
    n_chk++;
    bad = (take !== et);
    if (et) bad = bad | (cause !== ec) | (pbits !== ep) | (vector !== ev);
    else    bad = bad | (cause !== 4'h0) | (pbits !== 4'h0);
    if (bad) begin
      n_err++;
      $display("FAIL %s take=%0b/%0b cause=%h/%h prog=%h/%h vec=%h/%h",
               tag, take, et, cause, ec, pbits, ep, vector, ev);
    end
  endtask

  task automatic expect_stop(input logic es, input string tag);
    n_chk++;
    if (stop !== es) begin
      n_err++;
      $display("FAIL %s stop=%0b/%0b", tag, stop, es);
    end
  endtask

  // drive-at-negedge, then sample one edge later
  task automatic step(input logic et, input logic [3:0] ec, input logic [3:0] ep, input string tag);
    @(posedge clk); #1;
    expect_out(et, ec, ep, tag);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    vec_base = 32'h0;
    clr_all();
    #(CLK_T * 3);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    expect_out(0, 4'h0, 4'h0, "R1 reset");
    expect_stop(0, "R6 reset");
    step(0, 4'h0, 4'h0, "R1 idle");

    // R2 alignment sweep
    vec_base = 32'hFFF0_0000;
    for (int cls = 0; cls < 6; cls++)
      for (int ea = 0; ea < 4; ea++)
        for (int at = 0; at < 16; at++) begin
          logic exp_a;
          clr_instr();
          instr_valid = 1; ea_lo = ea[1:0];
          fp_mem = (cls == 0); lsm = (cls == 1); resv = (cls == 2); ext_ctl = (cls == 3); dcbz = (cls == 4);
          {page_ci, page_wt, dc_lock, dc_off} = at[3:0];
          exp_a = ((cls < 4) && ea != 0) || ((cls == 4) && at != 0);
          step(exp_a, exp_a ? 4'h6 : 4'h0, 4'h0, "R2 align");
        end

    // R3 program sweep
    for (int v = 0; v < 256; v++) begin
      logic [3:0] eb;
      clr_instr();
      instr_valid = 1;
      illegal = v[0]; unimpl = v[1]; priv = v[2]; msr_pr = v[3];
      spr_move = v[4]; spr_bad = v[5]; spr_msb = v[6]; trap_hit = v[7];
      eb = {v[7], v[3] & (v[2] | (v[4] & v[5] & v[6])), v[0] | v[1], 1'b0};
      step(eb != 0, (eb != 0) ? 4'h7 : 4'h0, eb, "R3 program");
    end
    msr_pr = 0;

    // R4/R5 FP sweep
    for (int op = 0; op < 2; op++)
      for (int mem = 0; mem < 2; mem++)
        for (int av = 0; av < 2; av++)
          for (int fe = 0; fe < 4; fe++)
            for (int st = 0; st < 4; st++)
              for (int en = 0; en < 4; en++) begin
                logic e_fpu, e_fpe;
                clr_instr();
                instr_valid = 1; fp_op = op[0]; fp_mem = mem[0]; msr_fp = av[0];
                {msr_fe1, msr_fe0} = fe[1:0];
                fpx_stat = FPX_W'(st) << 2; fpx_en = FPX_W'(en) << 2;
                e_fpu = (op[0] | mem[0]) & ~av[0];
                e_fpe = op[0] & av[0] & ((st & en) != 0) & (fe != 0);
                if (e_fpu)      step(1, 4'h8, 4'h0, "R5 fp unavailable");
                else if (e_fpe) step(1, 4'h7, 4'h1, "R4 fp enabled");
                else            step(0, 4'h0, 4'h0, "R4 fp quiet");
              end
    msr_fp = 1; msr_fe0 = 0; msr_fe1 = 0; fpx_stat = '0; fpx_en = '0;

    // R8 trace sweep
    for (int v = 0; v < 16; v++) begin
      logic e_t;
      clr_instr();
      instr_valid = 1; msr_se = v[0]; msr_be = v[1]; branch = v[2]; rfi = v[3];
      e_t = (v[0] & ~v[3]) | (v[1] & v[2]);
      step(e_t, e_t ? 4'hD : 4'h0, 4'h0, "R8 trace");
    end
    msr_se = 0; msr_be = 0;

    // R9 system call alone
    clr_instr(); instr_valid = 1; sc = 1;
    step(1, 4'hC, 4'h0, "R9 syscall");

    // R10 synchronous priority sweep
    vec_base = 32'h0001_0000;
    for (int v = 0; v < 32; v++) begin
      logic [3:0] ec;
      logic [3:0] ep;
      clr_instr();
      instr_valid = 1;
      illegal = v[0]; fp_op = v[1]; msr_fp = ~v[1]; lsm = v[2]; ea_lo = {1'b0, v[2]};
      sc = v[3]; msr_se = v[4];
      ep = 4'h0;
      if (v[0])      begin ec = 4'h7; ep = 4'h2; end
      else if (v[1]) ec = 4'h8;
      else if (v[2]) ec = 4'h6;
      else if (v[3]) ec = 4'hC;
      else if (v[4]) ec = 4'hD;
      else           ec = 4'h0;
      step(ec != 0, ec, ep, "R10 priority");
    end
    clr_all();
    step(0, 4'h0, 4'h0, "R1 quiet");

    // R7 decrementer edge, level held
    msr_ee = 1; dec_msb = 1;
    step(0, 4'h0, 4'h0, "R7 edge latency");
    step(1, 4'h9, 4'h0, "R7 dec taken");
    step(0, 4'h0, 4'h0, "R7 held high no retake");
    step(0, 4'h0, 4'h0, "R7 held high no retake 2");

    // R11 decrementer masked, then unmasked
    dec_msb = 0; msr_ee = 0;
    step(0, 4'h0, 4'h0, "R7 msb low");
    dec_msb = 1;
    step(0, 4'h0, 4'h0, "R11 dec masked");
    step(0, 4'h0, 4'h0, "R11 dec masked 2");
    msr_ee = 1;
    step(1, 4'h9, 4'h0, "R7 pending taken when enabled");

    // R7 clear drops pending
    dec_msb = 0; msr_ee = 0;
    step(0, 4'h0, 4'h0, "R7 msb low");
    dec_msb = 1;
    step(0, 4'h0, 4'h0, "R7 masked latch");
    dec_clr = 1;
    step(0, 4'h0, 4'h0, "R7 clear");
    dec_clr = 0; msr_ee = 1;
    step(0, 4'h0, 4'h0, "R7 cleared not taken");

    // R10 syscall beats pending decrementer
    dec_msb = 0;
    step(0, 4'h0, 4'h0, "R7 msb low");
    dec_msb = 1;
    step(0, 4'h0, 4'h0, "R7 latch");
    instr_valid = 1; sc = 1;
    step(1, 4'hC, 4'h0, "R10 sc over dec");
    clr_instr();
    step(1, 4'h9, 4'h0, "R10 dec after sc");

    // R11 external masked
    clr_all();
    ext_int = 1;
    step(0, 4'h0, 4'h0, "R11 ext masked");
    expect_stop(0, "R11 no stop when masked");
    step(0, 4'h0, 4'h0, "R11 ext masked 2");
    expect_stop(0, "R11 no stop when masked 2");

    // R6 drain sequence with draining exception
    msr_ee = 1; pipe_empty = 0;
    @(posedge clk); #1;
    expect_out(0, 4'h0, 4'h0, "R6 drain wait");
    expect_stop(1, "R6 stop raised");
    @(negedge clk);
    step(0, 4'h0, 4'h0, "R6 not empty");
    instr_valid = 1; sc = 1;
    @(posedge clk); #1;
    expect_out(1, 4'hC, 4'h0, "R6 draining exception first");
    expect_stop(1, "R6 stop held");
    @(negedge clk);
    clr_instr(); pipe_empty = 1;
    @(posedge clk); #1;
    expect_out(1, 4'h5, 4'h0, "R6 ext after drain");
    expect_stop(0, "R6 stop released");
    @(negedge clk);
    ext_int = 0;
    step(0, 4'h0, 4'h0, "R6 quiet after");

    // R10 decrementer and external raised together
    vec_base = 32'h0000_3000;
    dec_msb = 0;
    step(0, 4'h0, 4'h0, "R7 msb low");
    dec_msb = 1; ext_int = 1;
    @(posedge clk); #1;
    expect_out(0, 4'h0, 4'h0, "R10 both latched");
    expect_stop(1, "R6 stop");
    @(negedge clk);
    step(1, 4'h9, 4'h0, "R10 dec before ext");
    @(posedge clk); #1;
    expect_out(1, 4'h5, 4'h0, "R10 ext after dec");
    @(negedge clk);
    ext_int = 0;
    step(0, 4'h0, 4'h0, "R1 quiet end");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule